// File: doc/BRIEF.md
# Wide Unsigned Divider (128 by 64, quotient and remainder)

This block divides an unsigned 128-bit dividend by an unsigned 64-bit divisor. It returns a 64-bit quotient and a 64-bit remainder from the same operation. The dividend arrives as two 64-bit halves, an upper word and a lower word. The block is meant for multi-word integer arithmetic: a long-division routine feeds each partial remainder back in as the upper word of the next step.

Before any iteration starts, the operands are screened. If the divisor is zero, or the upper word is not below the divisor, the quotient would not fit in 64 bits. In that case the block skips the divide and returns saturated values: an all-ones quotient, a zero remainder and a raised overflow flag. When the operands pass the screen, a radix-2 restoring loop produces one quotient bit per clock. The upper word is below the divisor, so 64 bits of quotient are enough.

Operands enter through a valid/ready handshake and results leave through a second valid/ready handshake. Only one operation is in flight at a time.

Top module: `wide_udiv`

## Requirements
- R1: For accepted operands with divisor d nonzero and upper word hi < d (unsigned), the block computes the dividend {hi, lo}, with hi in bits 127:64 and lo in bits 63:0. The result satisfies res_quo * d + res_rem == {hi, lo}, where res_quo is the quotient and res_rem is the remainder of that dividend divided by the zero-extended divisor.
- R2: In that normal case, res_rem is strictly less than the divisor.
- R3: When hi >= d (unsigned) with d nonzero, the result is res_quo = all ones, res_rem = 0 and res_ovf = 1.
- R4: When d is zero, the result is the same saturated one (all-ones quotient, zero remainder, res_ovf = 1), whatever hi and lo hold.
- R5: res_ovf is 0 on every normal (non-saturated) result.
- R6: A saturated result is presented (res_valid = 1) in the clock cycle right after the cycle in which the operands were accepted.
- R7: A normal result is presented 64 clock edges after the accepting edge. With one quotient bit per cycle, res_valid rises on the 64th edge after acceptance.
- R8: op_ready is 1 only when no divide is running and no result is waiting. Operands offered while op_ready is 0 are ignored and leave the pending result unchanged.
- R9: While res_valid is 1 and res_ready is 0, res_valid stays 1 and res_quo, res_rem and res_ovf hold their values. A result is released on a clock edge with res_ready = 1, and op_ready returns to 1 in the next cycle.
- R10: After synchronous reset, op_ready is 1 and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operands are offered |
| op_ready | output | 1 | Block can accept operands this cycle |
| op_hi | input | 64 | Upper word of the dividend |
| op_lo | input | 64 | Lower word of the dividend |
| op_dvs | input | 64 | Divisor |
| res_valid | output | 1 | Result is available |
| res_ready | input | 1 | Consumer takes the result |
| res_quo | output | 64 | Quotient, or all ones on overflow |
| res_rem | output | 64 | Remainder, or zero on overflow |
| res_ovf | output | 1 | Saturated result (overflow or zero divisor) |

## Verification
Result timing depends on the screen. A saturated result must show on the first sample after the accepting edge. A normal result must show exactly 64 edges later, which the bench sees on its 65th falling-edge sample counted from that acceptance. The bench counts falling-edge samples from the accepting edge until res_valid appears and compares the count with the value due for the screen outcome. It reads the quotient, remainder and flag only at that sample, and again during an enforced stall with res_ready low. A decoy operand offered mid-divide must leave the later result unchanged.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    parameter int unsigned DW = 64;
    localparam int unsigned CW = $clog2(DW);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } udiv_state_t;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic [DW-1:0] dvs;
    } udiv_req_t;

    typedef struct packed {
        logic [DW-1:0] rem;
        logic [DW-1:0] quo;
    } udiv_acc_t;

    function automatic udiv_acc_t sat_result();
        udiv_acc_t r;
        r.rem = '0;
        r.quo = '1;
        return r;
    endfunction

endpackage

// File: rtl/udiv_guard.sv
module udiv_guard
    import udiv_pkg::*;
(
    input  udiv_req_t req,
    output logic      saturate
);
    logic zero_dvs;
    logic hi_too_big;

    always_comb begin
        zero_dvs   = (req.dvs == '0);
        hi_too_big = (req.hi >= req.dvs);
        saturate   = zero_dvs | hi_too_big;
    end
endmodule

// File: rtl/udiv_step.sv
module udiv_step
    import udiv_pkg::*;
(
    input  udiv_acc_t     acc_in,
    input  logic [DW-1:0] dvs,
    output udiv_acc_t     acc_out
);
    logic [DW:0]   partial;
    logic [DW+1:0] trial;
    logic          fits;

    always_comb begin
        partial = {acc_in.rem, acc_in.quo[DW-1]};
        trial   = {1'b0, partial} - {2'b00, dvs};
        fits    = ~trial[DW+1];
        acc_out.rem = fits ? trial[DW-1:0] : partial[DW-1:0];
        acc_out.quo = {acc_in.quo[DW-2:0], fits};
    end
endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic op_valid,
    input  logic saturate,
    input  logic res_ready,
    output logic op_ready,
    output logic res_valid,
    output logic load_run,
    output logic load_sat,
    output logic step_en
);
    udiv_state_t    state_q;
    udiv_state_t    state_d;
    logic [CW-1:0]  cnt_q;
    logic           last_step;
    logic           accept;

    always_comb begin
        op_ready  = (state_q == ST_IDLE);
        res_valid = (state_q == ST_DONE);
        accept    = op_ready & op_valid;
        load_run  = accept & ~saturate;
        load_sat  = accept & saturate;
        step_en   = (state_q == ST_RUN);
        last_step = step_en & (cnt_q == CW'(DW - 1));
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_sat)      state_d = ST_DONE;
                else if (load_run) state_d = ST_RUN;
            end
            ST_RUN:  if (last_step) state_d = ST_DONE;
            ST_DONE: if (res_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_run)     cnt_q <= '0;
            else if (step_en) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wide_udiv.sv
module wide_udiv
    import udiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic [DW-1:0] op_hi,
    input  logic [DW-1:0] op_lo,
    input  logic [DW-1:0] op_dvs,
    output logic          res_valid,
    input  logic          res_ready,
    output logic [DW-1:0] res_quo,
    output logic [DW-1:0] res_rem,
    output logic          res_ovf
);
    udiv_req_t     req;
    udiv_acc_t     acc_q;
    udiv_acc_t     acc_next;
    logic [DW-1:0] dvs_q;
    logic          ovf_q;
    logic          saturate;
    logic          load_run;
    logic          load_sat;
    logic          step_en;

    assign req.hi  = op_hi;
    assign req.lo  = op_lo;
    assign req.dvs = op_dvs;

    udiv_guard u_guard (
        .req      (req),
        .saturate (saturate)
    );

    udiv_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .saturate  (saturate),
        .res_ready (res_ready),
        .op_ready  (op_ready),
        .res_valid (res_valid),
        .load_run  (load_run),
        .load_sat  (load_sat),
        .step_en   (step_en)
    );

    udiv_step u_step (
        .acc_in  (acc_q),
        .dvs     (dvs_q),
        .acc_out (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            dvs_q <= '0;
            ovf_q <= 1'b0;
        end else if (load_sat) begin
            acc_q <= sat_result();
            ovf_q <= 1'b1;
        end else if (load_run) begin
            acc_q.rem <= op_hi;
            acc_q.quo <= op_lo;
            dvs_q     <= op_dvs;
            ovf_q     <= 1'b0;
        end else if (step_en) begin
            acc_q <= acc_next;
        end
    end

    assign res_quo = acc_q.quo;
    assign res_rem = acc_q.rem;
    assign res_ovf = ovf_q;
endmodule

// File: rtl/udiv_chk.sv
module udiv_chk
    import udiv_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic          op_ready,
    input logic [DW-1:0] op_hi,
    input logic [DW-1:0] op_dvs,
    input logic          res_valid,
    input logic          res_ready,
    input logic [DW-1:0] res_quo,
    input logic [DW-1:0] res_rem,
    input logic          res_ovf
);
    logic [DW-1:0] seen_dvs;

    always_ff @(posedge clk) begin
        if (rst) seen_dvs <= '0;
        else if (op_valid && op_ready) seen_dvs <= op_dvs;
    end

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_ready, res_valid}));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_quo) && $stable(res_rem) && $stable(res_ovf)));

    // R3
    sat_values_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ovf) |-> (res_quo == '1 && res_rem == '0));

    // R6
    sat_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && (op_dvs == '0 || op_hi >= op_dvs)) |=> (res_valid && res_ovf));

    // R7
    run_not_early_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_dvs != '0 && op_hi < op_dvs) |=> !res_valid);

    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ovf) |-> (res_rem < seen_dvs));
endmodule

bind wide_udiv udiv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_hi     (op_hi),
    .op_dvs    (op_dvs),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_quo   (res_quo),
    .res_rem   (res_rem),
    .res_ovf   (res_ovf)
);

// File: tb/sim_wide_udiv.sv
module sim_wide_udiv;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic         op_ready;
    logic [W-1:0] op_hi = '0;
    logic [W-1:0] op_lo = '0;
    logic [W-1:0] op_dvs = '0;
    logic         res_valid;
    logic         res_ready = 1'b0;
    logic [W-1:0] res_quo;
    logic [W-1:0] res_rem;
    logic         res_ovf;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    wide_udiv u0 (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_ready  (op_ready),
        .op_hi     (op_hi),
        .op_lo     (op_lo),
        .op_dvs    (op_dvs),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_quo   (res_quo),
        .res_rem   (res_rem),
        .res_ovf   (res_ovf)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_sat(input logic [W-1:0] hi, input logic [W-1:0] d);
        return (d == '0) || (hi >= d);
    endfunction

    function automatic logic [W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic run_op(input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] d, input bit hold);
        logic [127:0] dividend;
        logic [127:0] eq;
        logic [127:0] er;
        logic [W-1:0] q0;
        logic [W-1:0] r0;
        bit sat;
        int n;
        sat = is_sat(hi, d);
        dividend = {hi, lo};
        if (!sat) begin
            eq = dividend / {64'd0, d};
            er = dividend % {64'd0, d};
        end else begin
            eq = {64'd0, {W{1'b1}}};
            er = '0;
        end
        @(negedge clk);
        check(op_ready == 1'b1, "R8 ready before op", 128'(op_ready), 128'd1);
        op_valid = 1'b1; op_hi = hi; op_lo = lo; op_dvs = d;
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) op_valid = 1'b0;
            if (n == 3 && !res_valid) begin
                check(op_ready == 1'b0, "R8 busy not ready", 128'(op_ready), 128'd0);
                op_valid = 1'b1; op_hi = rnd64(); op_lo = rnd64(); op_dvs = rnd64();
            end
            if (n == 4) op_valid = 1'b0;
        end while (!res_valid && n < 200);
        if (sat) check(n == 1, "R6 saturated latency", 128'(n), 128'd1);
        else     check(n == W + 1, "R7 normal latency", 128'(n), 128'(W + 1));
        if (sat) begin
            if (d == '0) begin
                check(res_quo == '1 && res_rem == '0 && res_ovf, "R4 zero divisor",
                      {res_quo, res_rem}, {{W{1'b1}}, 64'd0});
            end else begin
                check(res_quo == '1 && res_rem == '0 && res_ovf, "R3 overflow saturate",
                      {res_quo, res_rem}, {{W{1'b1}}, 64'd0});
            end
        end else begin
            check(res_quo == eq[W-1:0], "R1 quotient", 128'(res_quo), eq);
            check(res_rem == er[W-1:0], "R1 remainder", 128'(res_rem), er);
            check(({64'd0, res_quo} * {64'd0, d} + {64'd0, res_rem}) == dividend,
                  "R1 reconstruct", {64'd0, res_quo} * {64'd0, d} + {64'd0, res_rem}, dividend);
            check(res_rem < d, "R2 remainder below divisor", 128'(res_rem), 128'(d));
            check(res_ovf == 1'b0, "R5 no overflow flag", 128'(res_ovf), 128'd0);
        end
        if (hold) begin
            q0 = res_quo; r0 = res_rem;
            repeat (3) @(negedge clk);
            check(res_valid && res_quo == q0 && res_rem == r0 && !op_ready, "R9 stall hold",
                  {res_quo, res_rem}, {q0, r0});
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(!res_valid && op_ready, "R9 release", {126'd0, res_valid, op_ready}, 128'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240511));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(op_ready == 1'b1 && res_valid == 1'b0, "R10 reset state",
              {126'd0, op_ready, res_valid}, 128'd2);
        run_op(64'd0, 64'd0, 64'd1, 1'b0);
        run_op(64'd0, {W{1'b1}}, 64'd1, 1'b1);
        run_op({W{1'b1}} - 64'd1, {W{1'b1}}, {W{1'b1}}, 1'b0);
        run_op(64'd0, 64'd5, 64'd7, 1'b0);
        run_op(64'd123, 64'd456, 64'd0, 1'b1);
        run_op(64'd0, 64'd9, 64'd0, 1'b0);
        run_op(64'd77, 64'd1, 64'd77, 1'b0);
        run_op(64'd78, 64'd1, 64'd77, 1'b1);
        run_op(64'h8000_0000_0000_0000, 64'd0, 64'h8000_0000_0000_0001, 1'b0);
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] d;
            logic [W-1:0] hi;
            d = rnd64();
            if (i % 4 == 1) d = 64'($urandom());
            hi = rnd64();
            if (i % 5 != 0 && d != '0) hi = hi % d;
            run_op(hi, rnd64(), d, (i % 7) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule